// File: doc/BRIEF.md
# Programmable Serial Peripheral Interface Master

This block is a full-duplex SPI master that software drives through a small word-addressed register file. Software first writes a configuration word and then writes a data word to the transmit location. The block shifts that word out on `mosi` and, at the same time, collects the same number of bits from `miso`. The collected bits can instead come from its own output stream when loopback is selected. When the transfer ends, the received word is placed in the receive location and a "data available" event is raised. A second event, "ready", tells software that a new word can be accepted. Each event can be routed to a single interrupt line through a mask of the same shape.

The following are all fields of the configuration word:
- clock polarity and phase
- bit order
- word length
- loopback
- a baud rate built from a 4-bit prescale modulus and an optional extra divide-by-16

Chip selects are driven outside the block.

The sequencer has three states:
- `ST_OFF`: disabled.
- `ST_IDLE`: enabled and ready.
- `ST_RUN`: shifting a word.

The transitions are:
- enable-set (`ST_OFF`→`ST_IDLE`)
- enable-clear (`ST_IDLE`→`ST_OFF`)
- start (`ST_IDLE`→`ST_RUN`, on a transmit write)
- finish (`ST_RUN`→`ST_IDLE`, after the last clock edge)
- abort (`ST_RUN`→`ST_OFF`, when enable is cleared mid-word)

Top module: `spi_regmaster`

## Requirements
- R1: After reset, the configuration, event and mask locations read zero, and `sclk`, `mosi` and `irq` are all low.
- R2: One SCLK half period lasts 2·(P+1) system clock cycles. P is the prescale modulus in configuration bits 19:16. When configuration bit 27 is set, the half period is 16 times longer. The data-available event of an N-bit word becomes visible exactly 2·N·half system cycles after the cycle that accepts the transmit write.
- R3: The word length comes from configuration bits 23:20. A code c from 3 to 15 selects c+1 bits, and code 0 selects 32 bits. A received word is right-aligned in the receive location, and its unused upper bits read zero.
- R4: When configuration bit 26 is set, the most significant bit goes first on the wire. When it is clear, the least significant bit goes first. Received bits are assembled in the same order.
- R5: Configuration bit 29 sets the idle level of `sclk`. With bit 28 clear, data is valid before the first edge and is sampled on leading edges. With bit 28 set, data changes on leading edges and is sampled on trailing edges.
- R6: When configuration bit 30 is set, the receiver takes the transmitted bit stream and `miso` is ignored. When it is clear, the receiver samples `miso`.
- R7: Event bit 9 (data available) sets when a word completes. Event bit 8 (ready) sets when the block becomes enabled or finishes a word, and clears when a transfer starts. Writing 1 to an event bit clears it. A set in the same cycle wins over the clear.
- R8: `irq` is high exactly when some event bit is set and its mask bit at the same position (9 or 8) is set.
- R9: A transmit write starts a transfer only when enable (configuration bit 24) is set and no word is in flight. Any other transmit write leaves the receive location and the events untouched.
- R10: Clearing the enable bit during a transfer ends it. `sclk` returns to the idle level on the next cycle, no data-available event is raised, and the receive location keeps its old value.
- R11: Locations are word indices on `bus_addr`: 0 configuration (read/write), 1 events, 2 mask, 3 transmit (write only), 4 receive (read only). Unmapped reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from `bus_addr`) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Masked event interrupt |

## Verification
The data-available event is due exactly 2·N·half clock edges after the edge that accepts the transmit write. The bench counts falling edges from that write and reads the event location one edge before the due time, where it must still be clear, and again on the due edge, where it must be set. The ready event and the interrupt respond one edge after the causing write or completion, so they are read on the following falling edge. After an abort, the idle level of `sclk` is checked on the first falling edge after the configuration write. Received words are pushed into a scoreboard and compared against the words the requirements predict. Serial bits are captured on the bench side at the sampling edge that the programmed phase selects.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;

    localparam int DW = 32;

    // configuration field positions (software decodes these)
    localparam int B_LOOP   = 30;
    localparam int B_CPOL   = 29;
    localparam int B_CPHA   = 28;
    localparam int B_SLOW   = 27;
    localparam int B_MSB    = 26;
    localparam int B_MASTER = 25;
    localparam int B_EN     = 24;
    localparam int LEN_LO   = 20;
    localparam int LEN_W    = 4;
    localparam int PM_LO    = 16;

    // event / mask bit positions
    localparam int EV_DAV = 9;
    localparam int EV_RDY = 8;

    typedef enum logic [2:0] {
        A_CFG   = 3'd0,
        A_EVENT = 3'd1,
        A_MASK  = 3'd2,
        A_TX    = 3'd3,
        A_RX    = 3'd4
    } reg_addr_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;

    // length code to bit count: 0 means a full 32-bit word
    function automatic logic [5:0] code_to_bits(input logic [LEN_W-1:0] code);
        if (code == '0) return 6'd32;
        return 6'({2'b00, code}) + 6'd1;
    endfunction

endpackage

// File: rtl/spi_rm_baud.sv
module spi_rm_baud #(
    parameter int PM_W    = 4,
    parameter int SLOW_SH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PM_W-1:0] pm,
    input  logic            slow,
    output logic            tick
);
    localparam int CW = PM_W + SLOW_SH + 2;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] half;

    always_comb begin
        half = (CW'(pm) + CW'(1)) << (slow ? (SLOW_SH + 1) : 1);
        tick = run && (cnt_q == half - CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + CW'(1);
    end

    // half period is at least two cycles, so ticks never touch
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/spi_rm_shift.sv
module spi_rm_shift #(
    parameter int DW   = 32,
    parameter int NB_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            preload,
    input  logic            shift_out,
    input  logic            sample,
    input  logic            msb_first,
    input  logic [NB_W-1:0] nbits,
    input  logic [DW-1:0]   tx_word,
    input  logic            din,
    output logic            mosi,
    output logic [DW-1:0]   rx_word
);
    localparam int SW = NB_W + 1;

    logic [DW-1:0] tx_sh_q;
    logic [DW-1:0] rx_sh_q;
    logic          mosi_q;
    logic [SW-1:0] pad;
    logic [DW-1:0] aligned;
    logic [DW-1:0] rx_next;
    logic [DW-1:0] rx_view;

    function automatic logic head_bit(input logic [DW-1:0] v, input logic msb);
        return msb ? v[DW-1] : v[0];
    endfunction

    function automatic logic [DW-1:0] advance(input logic [DW-1:0] v, input logic msb);
        return msb ? (v << 1) : (v >> 1);
    endfunction

    always_comb begin
        pad     = SW'(DW) - SW'(nbits);
        aligned = msb_first ? (tx_word << pad) : tx_word;
        rx_next = msb_first ? {rx_sh_q[DW-2:0], din} : {din, rx_sh_q[DW-1:1]};
        rx_view = sample ? rx_next : rx_sh_q;
        rx_word = msb_first ? rx_view : (rx_view >> pad);
        mosi    = mosi_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            mosi_q  <= 1'b0;
        end else if (load) begin
            rx_sh_q <= '0;
            if (preload) begin
                mosi_q  <= head_bit(aligned, msb_first);
                tx_sh_q <= advance(aligned, msb_first);
            end else begin
                tx_sh_q <= aligned;
            end
        end else begin
            if (shift_out) begin
                mosi_q  <= head_bit(tx_sh_q, msb_first);
                tx_sh_q <= advance(tx_sh_q, msb_first);
            end
            if (sample) rx_sh_q <= rx_next;
        end
    end

    // a word load never coincides with a bit edge
    p_load_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!shift_out && !sample));

endmodule

// File: rtl/spi_rm_ctrl.sv
module spi_rm_ctrl
    import spi_rm_pkg::*;
#(
    parameter int NB_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            cpha,
    input  logic            start_req,
    input  logic            tick,
    input  logic [NB_W-1:0] nbits,
    output logic            busy,
    output logic            load,
    output logic            shift_out,
    output logic            sample,
    output logic            done,
    output logic            ready_rise,
    output logic            phase
);
    localparam int EW = NB_W + 1;

    seq_state_t    state_q, state_d;
    logic [EW-1:0] edge_q;
    logic          tog_q;
    logic          edge_ev;
    logic          leading;
    logic          last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (en) state_d = ST_IDLE;
            ST_IDLE: begin
                if (!en)            state_d = ST_OFF;
                else if (start_req) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en)              state_d = ST_OFF;
                else if (tick && last) state_d = ST_IDLE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state_q == ST_RUN);
        last       = (edge_q == ({1'b0, nbits} << 1) - EW'(1));
        leading    = !edge_q[0];
        edge_ev    = busy && en && tick;
        load       = (state_q == ST_IDLE) && en && start_req;
        sample     = edge_ev && (cpha ? !leading : leading);
        shift_out  = edge_ev && (cpha ? leading : !leading) && !last;
        done       = edge_ev && last;
        ready_rise = ((state_q == ST_OFF) && en) || done;
        phase      = tog_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
            tog_q  <= 1'b0;
        end else if (load) begin
            edge_q <= '0;
            tog_q  <= 1'b0;
        end else if (edge_ev) begin
            edge_q <= edge_q + EW'(1);
            tog_q  <= ~tog_q;
        end
    end

    p_start_needs_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(en) && $past(start_req)));

    p_disable_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);

    // the last edge is always a trailing edge
    p_word_even_edges_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> tog_q);

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
    import spi_rm_pkg::*;
#(
    parameter int PM_W    = 4,
    parameter int SLOW_SH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        irq
);
    localparam int NB_W = 6;

    logic [DW-1:0] cfg_q;
    logic [DW-1:0] rx_q;
    logic          dav_q, rdy_q;
    logic          mdav_q, mrdy_q;

    logic            wr_en;
    logic            en, cpol, cpha, loop, msb_first, slow;
    logic [PM_W-1:0] pm;
    logic [NB_W-1:0] nbits;
    logic            start_req, clr_dav, clr_rdy;
    logic            busy, load, shift_out, sample, done, ready_rise, phase;
    logic            tick, din;
    logic [DW-1:0]   rx_word;

    always_comb begin
        wr_en     = bus_sel && bus_wr;
        en        = cfg_q[B_EN];
        cpol      = cfg_q[B_CPOL];
        cpha      = cfg_q[B_CPHA];
        loop      = cfg_q[B_LOOP];
        msb_first = cfg_q[B_MSB];
        slow      = cfg_q[B_SLOW];
        pm        = cfg_q[PM_LO +: PM_W];
        nbits     = code_to_bits(cfg_q[LEN_LO +: LEN_W]);
        start_req = wr_en && (bus_addr == A_TX);
        clr_dav   = wr_en && (bus_addr == A_EVENT) && bus_wdata[EV_DAV];
        clr_rdy   = wr_en && (bus_addr == A_EVENT) && bus_wdata[EV_RDY];
        din       = loop ? mosi : miso;
        sclk      = busy ? (cpol ^ phase) : cpol;
        irq       = (dav_q && mdav_q) || (rdy_q && mrdy_q);
    end

    spi_rm_baud #(.PM_W(PM_W), .SLOW_SH(SLOW_SH)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .pm   (pm),
        .slow (slow),
        .tick (tick)
    );

    spi_rm_ctrl #(.NB_W(NB_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cpha      (cpha),
        .start_req (start_req),
        .tick      (tick),
        .nbits     (nbits),
        .busy      (busy),
        .load      (load),
        .shift_out (shift_out),
        .sample    (sample),
        .done      (done),
        .ready_rise(ready_rise),
        .phase     (phase)
    );

    spi_rm_shift #(.DW(DW), .NB_W(NB_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .preload  (!cpha),
        .shift_out(shift_out),
        .sample   (sample),
        .msb_first(msb_first),
        .nbits    (nbits),
        .tx_word  (bus_wdata),
        .din      (din),
        .mosi     (mosi),
        .rx_word  (rx_word)
    );

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            rx_q   <= '0;
            dav_q  <= 1'b0;
            rdy_q  <= 1'b0;
            mdav_q <= 1'b0;
            mrdy_q <= 1'b0;
        end else begin
            if (wr_en && (bus_addr == A_CFG)) cfg_q <= bus_wdata;
            if (wr_en && (bus_addr == A_MASK)) begin
                mdav_q <= bus_wdata[EV_DAV];
                mrdy_q <= bus_wdata[EV_RDY];
            end
            if (done) rx_q <= rx_word;

            if (done)         dav_q <= 1'b1;
            else if (clr_dav) dav_q <= 1'b0;

            if (ready_rise)   rdy_q <= 1'b1;
            else if (load)    rdy_q <= 1'b0;
            else if (clr_rdy) rdy_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CFG:   bus_rdata = cfg_q;
            A_EVENT: begin
                bus_rdata[EV_DAV] = dav_q;
                bus_rdata[EV_RDY] = rdy_q;
            end
            A_MASK: begin
                bus_rdata[EV_DAV] = mdav_q;
                bus_rdata[EV_RDY] = mrdy_q;
            end
            A_RX:    bus_rdata = rx_q;
            default: bus_rdata = '0;
        endcase
    end

    p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mdav_q && !mrdy_q) |-> !irq);

    p_dav_from_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dav_q) |-> $past(busy));

    p_abort_no_dav_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en) |=> !$rose(dav_q));

endmodule

// File: tb/sim_spi_regmaster.sv
module sim_spi_regmaster;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, irq;
    logic        miso = 1'b0;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    logic [31:0] got_q[$];
    string       tag_q[$];

    bit          cap_cpol = 1'b0, cap_cpha = 1'b0;
    logic [31:0] cap_word = 32'd0;

    always #10 clk = ~clk;

    spi_regmaster u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq)
    );

    // serial capture at the sampling edge chosen by the phase setting
    always @(sclk) begin
        if (((sclk != cap_cpol) ? 1'b1 : 1'b0) ^ cap_cpha)
            cap_word = {cap_word[30:0], mosi};
    end

    // scoreboard monitor
    always @(negedge clk) begin
        while (got_q.size() != 0 && exp_q.size() != 0) begin
            logic [31:0] g, e;
            string t;
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (g !== e) begin
                errors++;
                $display("FAIL %s rx word: got %h expected %h", t, g, e);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] mk_cfg(input bit lp, input bit cpol, input bit cpha,
            input bit slow, input bit msb, input bit en, input int code, input int pm);
        logic [31:0] v;
        v = 32'd0;
        v[30] = lp; v[29] = cpol; v[28] = cpha; v[27] = slow;
        v[26] = msb; v[25] = 1'b1; v[24] = en;
        v[23:20] = 4'(code); v[19:16] = 4'(pm);
        return v;
    endfunction

    function automatic logic [31:0] lowmask(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    endfunction

    function automatic logic [31:0] bitrev(input logic [31:0] w, input int n);
        logic [31:0] r;
        r = 32'd0;
        for (int i = 0; i < n; i++) r[n-1-i] = w[i];
        return r;
    endfunction

    task automatic configure(input logic [31:0] cfg);
        bus_write(3'd0, 32'd0);
        bus_write(3'd0, cfg);
        cap_cpol = cfg[29];
        cap_cpha = cfg[28];
        @(negedge clk);
    endtask

    // driver: one word, with exact completion timing
    task automatic xfer(input logic [31:0] word, input int n, input int half,
            input logic [31:0] exp_rx, input logic [31:0] exp_cap, input string req);
        logic [31:0] ev, rx;
        bus_write(3'd1, 32'h300);
        cap_word = 32'd0;
        exp_q.push_back(exp_rx);
        tag_q.push_back(req);
        bus_write(3'd3, word);
        repeat (2*n*half - 1) @(negedge clk);
        bus_read(3'd1, ev);
        check("R2 event bit9 one cycle early", {31'd0, ev[9]}, 32'd0);
        @(negedge clk);
        bus_read(3'd1, ev);
        check("R2/R7 event bit9 at due cycle", {31'd0, ev[9]}, 32'd1);
        bus_read(3'd4, rx);
        got_q.push_back(rx);
        check({req, " serial order"}, cap_word & lowmask(n), exp_cap);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        bus_read(3'd0, d); check("R1 cfg", d, 32'd0);
        bus_read(3'd1, d); check("R1 events", d, 32'd0);
        bus_read(3'd2, d); check("R1 mask", d, 32'd0);
        check("R1 pins", {29'd0, sclk, mosi, irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // mode 0, msb first, 8 bits, loopback, fastest rate (half = 2)
        configure(mk_cfg(1, 0, 0, 0, 1, 1, 7, 0));
        bus_read(3'd0, d); check("R11 cfg readback", d, mk_cfg(1, 0, 0, 0, 1, 1, 7, 0));
        bus_read(3'd1, d); check("R7 ready on enable", d, 32'h100);
        xfer(32'hA5, 8, 2, 32'hA5, 32'hA5, "R4 R6 msb loop");
        bus_read(3'd1, d); check("R7 both events after word", d, 32'h300);
        check("R8 irq masked off", {31'd0, irq}, 32'd0);
        bus_write(3'd2, 32'h200); @(negedge clk);
        check("R8 irq on data-available", {31'd0, irq}, 32'd1);
        bus_write(3'd1, 32'h200); @(negedge clk);
        check("R8 irq drops after clear", {31'd0, irq}, 32'd0);
        bus_write(3'd2, 32'h100); @(negedge clk);
        check("R8 irq on ready", {31'd0, irq}, 32'd1);
        bus_write(3'd1, 32'h100); @(negedge clk);
        bus_read(3'd1, d); check("R7 write-one clear", d, 32'd0);
        bus_write(3'd2, 32'h0);

        // cpol 1, cpha 1, lsb first, 12 bits
        configure(mk_cfg(1, 1, 1, 0, 0, 1, 11, 0));
        check("R5 idle level high", {31'd0, sclk}, 32'd1);
        xfer(32'hC3A, 12, 2, 32'hC3A, bitrev(32'hC3A, 12), "R4 R5 lsb cpha1");

        // cpol 0, cpha 1, msb first, 32-bit code
        configure(mk_cfg(1, 0, 1, 0, 1, 1, 0, 0));
        xfer(32'hDEADBEEF, 32, 2, 32'hDEADBEEF, 32'hDEADBEEF, "R3 32-bit");

        // miso path, 4 bits, prescale 1 (half = 4)
        miso = 1'b1;
        configure(mk_cfg(0, 0, 0, 0, 1, 1, 3, 1));
        xfer(32'h5, 4, 4, 32'hF, 32'h5, "R3 R6 miso 4-bit");
        configure(mk_cfg(1, 0, 0, 0, 1, 1, 3, 1));
        xfer(32'h5, 4, 4, 32'h5, 32'h5, "R6 loop ignores miso");
        configure(mk_cfg(0, 1, 0, 0, 0, 1, 15, 0));
        xfer(32'h1234, 16, 2, 32'hFFFF, bitrev(32'h1234, 16), "R3 R4 lsb miso 16-bit");
        miso = 1'b0;

        // slow divider: half = 32, and prescale 3: half = 8
        configure(mk_cfg(1, 0, 0, 1, 1, 1, 3, 0));
        xfer(32'h9, 4, 32, 32'h9, 32'h9, "R2 slow divider");
        configure(mk_cfg(1, 0, 0, 0, 1, 1, 4, 3));
        xfer(32'h16, 5, 8, 32'h16, 32'h16, "R2 prescale 3");

        // transmit write while busy is ignored
        configure(mk_cfg(1, 0, 0, 0, 1, 1, 7, 0));
        bus_write(3'd1, 32'h300);
        bus_write(3'd3, 32'h3C);
        repeat (3) @(negedge clk);
        bus_read(3'd1, d); check("R7 ready clears on start", d, 32'd0);
        bus_write(3'd3, 32'hFF);
        repeat (40) @(negedge clk);
        bus_read(3'd4, d); check("R9 busy write ignored", d, 32'h3C);

        // transmit write while disabled is ignored
        configure(mk_cfg(1, 0, 0, 0, 1, 0, 7, 0));
        bus_write(3'd1, 32'h300);
        bus_write(3'd3, 32'h81);
        repeat (60) @(negedge clk);
        bus_read(3'd1, d); check("R9 disabled write no event", d, 32'd0);
        bus_read(3'd4, d); check("R9 disabled write rx kept", d, 32'h3C);

        // abort mid-word, idle level high
        configure(mk_cfg(1, 1, 0, 0, 1, 1, 15, 3));
        bus_write(3'd1, 32'h300);
        bus_write(3'd3, 32'hBEEF);
        repeat (20) @(negedge clk);
        bus_write(3'd0, mk_cfg(1, 1, 0, 0, 1, 0, 15, 3));
        check("R10 sclk idle after abort", {31'd0, sclk}, 32'd1);
        repeat (300) @(negedge clk);
        bus_read(3'd1, d); check("R10 no event after abort", d, 32'd0);
        bus_read(3'd4, d); check("R10 rx kept after abort", d, 32'h3C);
        bus_read(3'd5, d); check("R11 unmapped reads zero", d, 32'd0);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule